// File: doc/BRIEF.md
# Eager-Forward Route Checker

This block is the input-side decision unit of a mesh switch that sends every arriving flit straight out of its preferred output without waiting for a route. The speculative copy leaves at once. The checker then judges that hop from three things: the flit's destination coordinates, the coordinates of this node, and the direction of the preferred output. A hop that brings the flit nearer its target on the X axis or on the Y axis is accepted as live. Any other hop is flagged dead, and the speculative copy is dropped where the preferred path ends.

Alongside that judgement, the checker computes the deterministic dimension-order output, which routes X first, then Y, then ejects to one of two local processing elements. It also decides whether the flit must be written into the queue for that output. A live speculative copy and a queued copy may both exist, so duplicates can reach the destination. The results are registered and appear one clock after the flit is presented.

Top module: `eager_route_check`

## Requirements
- R1: While reset is low, and on the first cycle after it, `res_vld`, `res_dead` and `res_enq` are 0 and `res_port` is 0.
- R2: Port codes are 0 north (Y increasing), 1 east (X increasing), 2 south, 3 west, 4 and 5 local elements. When the destination X differs from the node X, `res_port` is 1 if the destination X is larger and 3 if it is smaller.
- R3: When the X coordinates match and the Y coordinates differ, `res_port` is 0 if the destination Y is larger and 2 if it is smaller.
- R4: When both coordinates match, `res_port` is 4 plus `flit_pe`.
- R5: A preferred code of 0 to 3 whose direction reduces the distance on its own axis gives `res_dead` = 0, even when it is not the XY direction.
- R6: Away from the destination, `res_dead` = 1 when the preferred code is 0 to 3 and the hop moves away, or moves along an axis whose coordinates already match. A preferred code of 4 or 5 away from the destination also gives `res_dead` = 1.
- R7: A flit whose destination equals the node coordinates is never dead, whatever the preferred code.
- R8: `res_enq` = 1 exactly when the flit is dead or the preferred code differs from `res_port`, so a live copy and a queued copy can coexist.
- R9: Preferred codes 6 and 7 mean no preferred path. They give `res_dead` = 0 and `res_enq` = 1.
- R10: The results for a flit presented with `flit_vld` = 1 appear on the next rising edge with `res_vld` = 1. A cycle with `flit_vld` = 0 gives `res_vld`, `res_dead` and `res_enq` = 0 on the next edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flit_vld | input | 1 | A flit header is present this cycle |
| flit_dx | input | COORD_W | Destination X coordinate |
| flit_dy | input | COORD_W | Destination Y coordinate |
| flit_pe | input | 1 | Low destination bit that picks the local element |
| node_x | input | COORD_W | X coordinate of this node |
| node_y | input | COORD_W | Y coordinate of this node |
| pref_port | input | 3 | Code of the output this input is pre-connected to |
| res_vld | output | 1 | Registered results are valid |
| res_dead | output | 1 | The speculative hop was useless |
| res_enq | output | 1 | Write the flit into the queue of `res_port` |
| res_port | output | 3 | Output chosen by XY routing |

## Verification
Destinations are placed in every quadrant around the node, on each axis line, on the node itself, and at the corners of the coordinate range. These cases separate the X-first rule from the Y rule, show that the strict comparisons are correct, and confirm that zero-width or wrapped comparisons do not occur. For each placement, preferred directions are chosen that match the XY port, approach on the other axis, move away, move sideways along a matched axis, or point to a local element. This separates live-but-duplicated flits from single-copy flits and from dead ones. Cycles with `flit_vld` low carry non-zero fields, to show that those fields raise nothing. A flit followed by an idle cycle shows the one-cycle latency.

// File: rtl/erc_pkg.sv
// Package: shared port codes and the width of a port code for the
// eager-forward route checker. Assumes a 2-D mesh with two local elements.
package erc_pkg;
    localparam int PORT_W = 3;

    localparam logic [PORT_W-1:0] DIR_N   = 3'd0; // toward larger Y
    localparam logic [PORT_W-1:0] DIR_E   = 3'd1; // toward larger X
    localparam logic [PORT_W-1:0] DIR_S   = 3'd2; // toward smaller Y
    localparam logic [PORT_W-1:0] DIR_W   = 3'd3; // toward smaller X
    localparam logic [PORT_W-1:0] DIR_PE0 = 3'd4; // local element 0
    localparam logic [PORT_W-1:0] DIR_PE1 = 3'd5; // local element 1

    localparam int AXES = 2; // index 0 = X, index 1 = Y
endpackage

// File: rtl/erc_axis_cmp.sv
// Module: erc_axis_cmp
// Compares one destination coordinate with the node coordinate on a single
// axis and reports whether the target lies ahead (larger) or behind
// (smaller). Assumes unsigned coordinates; purely combinational.
module erc_axis_cmp #(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W-1:0] dst_c,
    input  logic [COORD_W-1:0] here_c,
    output logic               ahead,
    output logic               behind
);
    // Strict magnitude compare on one axis.
    always_comb begin
        ahead  = (dst_c > here_c);
        behind = (dst_c < here_c);
    end
endmodule

// File: rtl/erc_xy_route.sv
// Module: erc_xy_route
// Dimension-order output choice: X first, then Y, then eject to the local
// element picked by pe_bit. Assumes per-axis compare flags are mutually
// exclusive (from erc_axis_cmp).
module erc_xy_route
    import erc_pkg::*;
(
    input  logic [AXES-1:0]   ahead,
    input  logic [AXES-1:0]   behind,
    input  logic              pe_bit,
    output logic [PORT_W-1:0] xy_port,
    output logic              at_dest
);
    // Select the XY output from the axis flags in X, Y, local order.
    always_comb begin
        at_dest = ~(|ahead) & ~(|behind);
        if (ahead[0])       xy_port = DIR_E;
        else if (behind[0]) xy_port = DIR_W;
        else if (ahead[1])  xy_port = DIR_N;
        else if (behind[1]) xy_port = DIR_S;
        else if (pe_bit)    xy_port = DIR_PE1;
        else                xy_port = DIR_PE0;
    end
endmodule

// File: rtl/erc_hop_judge.sv
// Module: erc_hop_judge
// Judges the speculative hop on the preferred output: live when it moves the
// flit closer on at least one axis, dead otherwise. A flit already at its
// destination is never dead; codes above the last local port mean "no
// preferred path" and are never dead. Purely combinational.
module erc_hop_judge
    import erc_pkg::*;
(
    input  logic [AXES-1:0]   ahead,
    input  logic [AXES-1:0]   behind,
    input  logic              at_dest,
    input  logic [PORT_W-1:0] pref,
    output logic              dead,
    output logic              no_pref
);
    logic approach_x;
    logic approach_y;

    // Does the preferred mesh direction shrink the distance on its own axis?
    always_comb begin
        approach_x = ((pref == DIR_E) && ahead[0])  || ((pref == DIR_W) && behind[0]);
        approach_y = ((pref == DIR_N) && ahead[1])  || ((pref == DIR_S) && behind[1]);
    end

    // Dead unless approaching, at destination, or no preferred path exists.
    always_comb begin
        no_pref = (pref > DIR_PE1);
        dead    = ~at_dest & ~no_pref & ~(approach_x | approach_y);
    end
endmodule

// File: rtl/eager_route_check.sv
// Module: eager_route_check (top)
// Registers, one cycle after a flit header, the verdict on its speculative
// preferred-path hop (dead or live), the XY output and whether the flit must
// also be queued for that output. Assumes node coordinates are stable while
// flits arrive. Synchronous active-low reset.
module eager_route_check
    import erc_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flit_vld,
    input  logic [COORD_W-1:0] flit_dx,
    input  logic [COORD_W-1:0] flit_dy,
    input  logic               flit_pe,
    input  logic [COORD_W-1:0] node_x,
    input  logic [COORD_W-1:0] node_y,
    input  logic [2:0]         pref_port,
    output logic               res_vld,
    output logic               res_dead,
    output logic               res_enq,
    output logic [2:0]         res_port
);
    logic [AXES-1:0][COORD_W-1:0] dst_v;
    logic [AXES-1:0][COORD_W-1:0] here_v;
    logic [AXES-1:0]              ahead;
    logic [AXES-1:0]              behind;
    logic [PORT_W-1:0]            xy_port;
    logic                         at_dest;
    logic                         hop_dead;
    logic                         no_pref;
    logic                         need_enq;

    // Gather coordinates into per-axis vectors.
    always_comb begin
        dst_v[0]  = flit_dx;
        dst_v[1]  = flit_dy;
        here_v[0] = node_x;
        here_v[1] = node_y;
    end

    // One comparator per mesh axis.
    for (genvar a = 0; a < AXES; a++) begin : g_axis
        erc_axis_cmp #(.COORD_W(COORD_W)) u_cmp (
            .dst_c  (dst_v[a]),
            .here_c (here_v[a]),
            .ahead  (ahead[a]),
            .behind (behind[a])
        );
    end

    erc_xy_route u_xy (
        .ahead   (ahead),
        .behind  (behind),
        .pe_bit  (flit_pe),
        .xy_port (xy_port),
        .at_dest (at_dest)
    );

    erc_hop_judge u_judge (
        .ahead   (ahead),
        .behind  (behind),
        .at_dest (at_dest),
        .pref    (pref_port),
        .dead    (hop_dead),
        .no_pref (no_pref)
    );

    // Queue the flit when its speculative copy is lost or goes elsewhere.
    always_comb begin
        need_enq = hop_dead | no_pref | (pref_port != xy_port);
    end

    // Result register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            res_dead <= 1'b0;
            res_enq  <= 1'b0;
            res_port <= '0;
        end else begin
            res_vld  <= flit_vld;
            res_dead <= flit_vld & hop_dead;
            res_enq  <= flit_vld & need_enq;
            res_port <= xy_port;
        end
    end

    // Assertions guarding the registered outputs.
    p_dead_forces_enq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_dead |-> res_enq);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flit_vld |=> (!res_vld && !res_dead && !res_enq));

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flit_vld |=> res_vld);

    p_dest_never_dead_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_vld && flit_dx == node_x && flit_dy == node_y) |=> (!res_dead && res_port[2]));

    p_x_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_vld && flit_dx != node_x) |=> (res_port == DIR_E || res_port == DIR_W));

    p_no_pref_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_vld && pref_port[2:1] == 2'b11) |=> (!res_dead && res_enq));

    p_match_single_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_dead && !res_enq) |-> (res_port == $past(pref_port)));
endmodule

// File: tb/eager_route_check_test.sv
module eager_route_check_test;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          flit_vld;
    logic [CW-1:0] flit_dx, flit_dy, node_x, node_y;
    logic          flit_pe;
    logic [2:0]    pref_port;
    logic          res_vld, res_dead, res_enq;
    logic [2:0]    res_port;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk; // 200 MHz

    eager_route_check #(.COORD_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .flit_vld(flit_vld),
        .flit_dx(flit_dx), .flit_dy(flit_dy), .flit_pe(flit_pe),
        .node_x(node_x), .node_y(node_y), .pref_port(pref_port),
        .res_vld(res_vld), .res_dead(res_dead), .res_enq(res_enq),
        .res_port(res_port)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Present one flit, then check the results on the following cycle.
    task automatic flit(input int hx, input int hy, input int dx, input int dy,
                        input int pe, input int pref, input int e_dead,
                        input int e_enq, input int e_port, input string tag);
        @(negedge clk);
        node_x = hx[CW-1:0]; node_y = hy[CW-1:0];
        flit_dx = dx[CW-1:0]; flit_dy = dy[CW-1:0];
        flit_pe = pe[0]; pref_port = pref[2:0]; flit_vld = 1'b1;
        @(negedge clk);
        flit_vld = 1'b0;
        chk(res_vld == 1'b1, {tag, " R10 vld"}, int'(res_vld), 1);
        chk(int'(res_dead) == e_dead, {tag, " dead"}, int'(res_dead), e_dead);
        chk(int'(res_enq) == e_enq, {tag, " R8 enq"}, int'(res_enq), e_enq);
        chk(int'(res_port) == e_port, {tag, " port"}, int'(res_port), e_port);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; flit_vld = 1'b1; flit_dx = 4'd9; flit_dy = 4'd9;
        flit_pe = 1'b1; node_x = 4'd1; node_y = 4'd1; pref_port = 3'd3;
        repeat (3) @(negedge clk);
        chk(!res_vld && !res_dead && !res_enq && res_port == 3'd0, "R1 in reset",
            int'({res_vld, res_dead, res_enq, res_port}), 0);
        rst_n = 1'b1; flit_vld = 1'b0;
        @(negedge clk);
        chk(!res_vld && !res_dead && !res_enq, "R1 after reset",
            int'({res_vld, res_dead, res_enq}), 0);
    endtask

    task automatic t_xy_axis;
        flit(5, 5, 8, 2, 0, 1, 0, 0, 1, "R2 east match R5");
        flit(5, 5, 2, 9, 0, 3, 0, 0, 3, "R2 west match R5");
        flit(5, 5, 5, 9, 0, 0, 0, 0, 0, "R3 north match");
        flit(5, 5, 5, 1, 0, 2, 0, 0, 2, "R3 south match");
    endtask

    task automatic t_other_axis;
        flit(5, 5, 8, 9, 0, 0, 0, 1, 1, "R5 north live dup R8");
        flit(5, 5, 2, 1, 1, 2, 0, 1, 3, "R5 south live dup R8");
        flit(0, 0, 15, 15, 0, 0, 0, 1, 1, "R5 corner low");
        flit(15, 15, 0, 0, 0, 2, 0, 1, 3, "R5 corner high");
    endtask

    task automatic t_dead;
        flit(5, 5, 5, 1, 0, 1, 1, 1, 2, "R6 sideways east");
        flit(5, 5, 8, 5, 0, 3, 1, 1, 1, "R6 away west");
        flit(5, 5, 3, 5, 0, 2, 1, 1, 3, "R6 sideways south");
        flit(5, 5, 7, 7, 0, 4, 1, 1, 1, "R6 local off dest");
        flit(5, 5, 6, 4, 1, 5, 1, 1, 1, "R6 local1 off dest");
    endtask

    task automatic t_dest;
        flit(5, 5, 5, 5, 1, 5, 0, 0, 5, "R4 R7 pe1 match");
        flit(5, 5, 5, 5, 0, 0, 0, 1, 4, "R4 R7 mesh pref");
        flit(5, 5, 5, 5, 0, 5, 0, 1, 4, "R7 wrong pe");
    endtask

    task automatic t_no_pref;
        flit(5, 5, 2, 2, 0, 6, 0, 1, 3, "R9 code6");
        flit(5, 5, 5, 2, 0, 7, 0, 1, 2, "R9 code7");
    endtask

    task automatic t_idle;
        @(negedge clk);
        flit_vld = 1'b0; node_x = 4'd5; node_y = 4'd5;
        flit_dx = 4'd7; flit_dy = 4'd7; pref_port = 3'd4;
        @(negedge clk);
        chk(!res_vld && !res_dead && !res_enq, "R10 idle ignored",
            int'({res_vld, res_dead, res_enq}), 0);
        flit(5, 5, 9, 5, 0, 1, 0, 0, 1, "R10 single");
        @(negedge clk);
        chk(res_vld == 1'b0, "R10 one cycle only", int'(res_vld), 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_xy_axis();
        t_other_axis();
        t_dead();
        t_dest();
        t_no_pref();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule